// File: doc/BRIEF.md
# Dual-Bus System Address Decoder

This block routes a single 32-bit access from either of two processor cores to one of ten address regions. Each access carries the issuing core, the bus it travels on (data or instruction), the address, an access size and a write flag, all qualified by a valid strobe. The block looks the address up in a window table for the bus in use. It then applies the access rules: one fast memory can be reached only from core 0, the instruction bus takes only aligned words, and the flash windows are read only. The result is a one-hot region select together with the offset of the address from the base of the selected window, or a decode-error flag, or a misalignment flag.

The data bus covers the external windows, the peripheral window and the embedded memories below 0x4000_0000. The instruction bus covers the 0x4xxx_xxxx range. Both buses share the slow memory window at 0x5000_0000. An address that reaches a window belonging only to the other bus finds no match and is reported as a decode error. Every result is registered and appears exactly one cycle after the request. A small two-state sequencer (`ST_IDLE`, `ST_RESP`) produces the response strobe. The transition `ST_IDLE`/`ST_RESP` → `ST_RESP` is taken on a valid request. The transition `ST_RESP`/`ST_IDLE` → `ST_IDLE` is taken when no request is presented. Reset forces `ST_IDLE`.

Top module: `sys_addr_decoder`

## Requirements
- R1: Results appear on the outputs one clock after a valid request. `rsp_valid` is high exactly in the cycle after `req_valid` was high. While `rsp_valid` is low, every other output is zero. A synchronous active-high reset clears all outputs.
- R2: On the data bus, the following windows decode as shown, with the offset equal to the address minus the window base. 0x3F40_0000–0x3F7F_FFFF selects external flash. 0x3F80_0000–0x3FBF_FFFF selects external SRAM. 0x3FF0_0000–0x3FF7_FFFF selects the peripheral window.
- R3: On the data bus, the embedded windows decode as shown, each with its own base. 0x3FF8_0000–0x3FF8_1FFF selects RTC fast memory. 0x3FF9_0000–0x3FF9_FFFF selects ROM1. 0x3FFA_E000–0x3FFD_FFFF selects SRAM2. 0x3FFE_0000–0x3FFF_FFFF selects SRAM1.
- R4: On the instruction bus, the windows decode as shown. 0x4000_0000–0x4005_FFFF selects ROM0. 0x4007_0000–0x4009_FFFF selects SRAM0. 0x400A_0000–0x400B_FFFF selects SRAM1. 0x400C_0000–0x400C_1FFF selects RTC fast memory. 0x400C_2000–0x40BF_FFFF selects external flash.
- R5: 0x5000_0000–0x5000_1FFF selects RTC slow memory on either bus. Any address from 0x5000_2000 upward is a decode error.
- R6: An address below 0x4000_0000 on the instruction bus, or in 0x4000_0000–0x4FFF_FFFF on the data bus, is a decode error.
- R7: Reserved ranges are decode errors. These are everything on the data bus below 0x3F40_0000, 0x3FC0_0000–0x3FEF_FFFF, 0x3FF8_2000–0x3FF8_FFFF and 0x3FFA_0000–0x3FFA_DFFF, and 0x4006_0000–0x4006_FFFF on the instruction bus.
- R8: An access from core 1 (`req_core`=1) that hits either RTC fast memory window is a decode error and selects nothing.
- R9: An instruction-bus access (`req_ibus`=1) raises `rsp_misalign` and selects nothing, with no decode error, when the address bits [1:0] are non-zero or the size is not word. Size codes are 0 byte, 1 half-word and 2 word.
- R10: On the data bus, byte, half-word and word accesses are accepted at any alignment and never raise `rsp_misalign`.
- R11: A write (`req_write`=1) that hits an external flash window on either bus is a decode error.
- R12: Size code 3 is a decode error on either bus.
- R13: `rsp_sel` is zero or one-hot, with bit 0 external flash, 1 external SRAM, 2 peripherals, 3 ROM0, 4 ROM1, 5 SRAM0, 6 SRAM1, 7 SRAM2, 8 RTC fast and 9 RTC slow. In a response, exactly one of "some select", `rsp_dec_err` and `rsp_misalign` is high. The offset is zero whenever no region is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_core | input | 1 | Issuing core (0 or 1) |
| req_ibus | input | 1 | 1 = instruction bus, 0 = data bus |
| req_write | input | 1 | 1 = write access |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 illegal |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_sel | output | 10 | One-hot region select |
| rsp_offset | output | 32 | Address minus window base |
| rsp_dec_err | output | 1 | Decode error |
| rsp_misalign | output | 1 | Instruction-bus alignment exception |

## Verification
The bound checker watches several rules on every cycle. It checks the one-cycle request-to-response relation and the quiet outputs between responses. It checks that select, error and misalignment are mutually exclusive. It also checks the rules that depend only on request attributes: core 1 never reaches RTC fast memory, a write never selects flash, the instruction bus flags unaligned addresses, the data bus never flags them, and size code 3 always errors. Whether each address lands in the right window with the right offset, and whether every reserved gap edge is rejected, depends on the window tables. Only the bench's address vectors, chosen at window edges and in the gaps, can show those.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int ADDR_W  = 32;
    localparam int NUM_RGN = 10;
    localparam int RGN_W   = $clog2(NUM_RGN);

    // region indices, also the bit positions of the one-hot select
    localparam int RG_XFLASH  = 0;
    localparam int RG_XSRAM   = 1;
    localparam int RG_PERIPH  = 2;
    localparam int RG_ROM0    = 3;
    localparam int RG_ROM1    = 4;
    localparam int RG_SRAM0   = 5;
    localparam int RG_SRAM1   = 6;
    localparam int RG_SRAM2   = 7;
    localparam int RG_RTCFAST = 8;
    localparam int RG_RTCSLOW = 9;

    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [RGN_W-1:0]  rgn;
    } win_t;

    typedef enum logic [1:0] {
        V_SELECT,
        V_DECERR,
        V_MISALIGN
    } verdict_t;

    localparam int DBUS_N = 8;
    localparam int IBUS_N = 6;

    localparam win_t [DBUS_N-1:0] DBUS_WIN = '{
        '{32'h3F40_0000, 32'h3F7F_FFFF, RGN_W'(RG_XFLASH)},
        '{32'h3F80_0000, 32'h3FBF_FFFF, RGN_W'(RG_XSRAM)},
        '{32'h3FF0_0000, 32'h3FF7_FFFF, RGN_W'(RG_PERIPH)},
        '{32'h3FF8_0000, 32'h3FF8_1FFF, RGN_W'(RG_RTCFAST)},
        '{32'h3FF9_0000, 32'h3FF9_FFFF, RGN_W'(RG_ROM1)},
        '{32'h3FFA_E000, 32'h3FFD_FFFF, RGN_W'(RG_SRAM2)},
        '{32'h3FFE_0000, 32'h3FFF_FFFF, RGN_W'(RG_SRAM1)},
        '{32'h5000_0000, 32'h5000_1FFF, RGN_W'(RG_RTCSLOW)}
    };

    localparam win_t [IBUS_N-1:0] IBUS_WIN = '{
        '{32'h4000_0000, 32'h4005_FFFF, RGN_W'(RG_ROM0)},
        '{32'h4007_0000, 32'h4009_FFFF, RGN_W'(RG_SRAM0)},
        '{32'h400A_0000, 32'h400B_FFFF, RGN_W'(RG_SRAM1)},
        '{32'h400C_0000, 32'h400C_1FFF, RGN_W'(RG_RTCFAST)},
        '{32'h400C_2000, 32'h40BF_FFFF, RGN_W'(RG_XFLASH)},
        '{32'h5000_0000, 32'h5000_1FFF, RGN_W'(RG_RTCSLOW)}
    };

endpackage

// File: rtl/addr_window_match.sv
module addr_window_match
    import addr_dec_pkg::*;
#(
    parameter int            N   = 1,
    parameter win_t [N-1:0]  WIN = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [RGN_W-1:0]  rgn,
    output logic [ADDR_W-1:0] base
);

    logic [N-1:0] in_win;

    // one range comparator per window; windows are disjoint
    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign in_win[g] = (addr >= WIN[g].lo) && (addr <= WIN[g].hi);
        end
    endgenerate

    always_comb begin
        hit  = |in_win;
        rgn  = '0;
        base = '0;
        for (int i = 0; i < N; i++) begin
            if (in_win[i]) begin
                rgn  = WIN[i].rgn;
                base = WIN[i].lo;
            end
        end
    end

endmodule

// File: rtl/addr_access_check.sv
module addr_access_check
    import addr_dec_pkg::*;
(
    input  logic               ibus,
    input  logic               core,
    input  logic               wr,
    input  logic [1:0]         size,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               d_hit,
    input  logic [RGN_W-1:0]   d_rgn,
    input  logic [ADDR_W-1:0]  d_base,
    input  logic               i_hit,
    input  logic [RGN_W-1:0]   i_rgn,
    input  logic [ADDR_W-1:0]  i_base,
    output logic [NUM_RGN-1:0] sel,
    output logic [ADDR_W-1:0]  offset,
    output logic               dec_err,
    output logic               misalign
);

    logic              hit;
    logic [RGN_W-1:0]  rgn;
    logic [ADDR_W-1:0] base;
    verdict_t          verdict;

    assign hit  = ibus ? i_hit  : d_hit;
    assign rgn  = ibus ? i_rgn  : d_rgn;
    assign base = ibus ? i_base : d_base;

    // ordered rule chain: size code, alignment, window, core, write
    always_comb begin
        if (size == SZ_BAD)
            verdict = V_DECERR;
        else if (ibus && ((addr[1:0] != 2'b00) || (size != SZ_WORD)))
            verdict = V_MISALIGN;
        else if (!hit)
            verdict = V_DECERR;
        else if (core && (rgn == RGN_W'(RG_RTCFAST)))
            verdict = V_DECERR;
        else if (wr && (rgn == RGN_W'(RG_XFLASH)))
            verdict = V_DECERR;
        else
            verdict = V_SELECT;
    end

    always_comb begin
        sel      = '0;
        offset   = '0;
        dec_err  = 1'b0;
        misalign = 1'b0;
        unique case (verdict)
            V_SELECT: begin
                sel    = NUM_RGN'(1) << rgn;
                offset = addr - base;
            end
            V_DECERR:   dec_err  = 1'b1;
            V_MISALIGN: misalign = 1'b1;
            default:    dec_err  = 1'b1;
        endcase
    end

endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
    import addr_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_core,
    input  logic               req_ibus,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [NUM_RGN-1:0] rsp_sel,
    output logic [ADDR_W-1:0]  rsp_offset,
    output logic               rsp_dec_err,
    output logic               rsp_misalign
);

    typedef enum logic {ST_IDLE, ST_RESP} rsp_state_t;

    rsp_state_t         state_q, state_d;
    logic               d_hit, i_hit;
    logic [RGN_W-1:0]   d_rgn, i_rgn;
    logic [ADDR_W-1:0]  d_base, i_base;
    logic [NUM_RGN-1:0] c_sel;
    logic [ADDR_W-1:0]  c_off;
    logic               c_err, c_mis;

    addr_window_match #(.N(DBUS_N), .WIN(DBUS_WIN)) u_dbus_match (
        .addr (req_addr),
        .hit  (d_hit),
        .rgn  (d_rgn),
        .base (d_base)
    );

    addr_window_match #(.N(IBUS_N), .WIN(IBUS_WIN)) u_ibus_match (
        .addr (req_addr),
        .hit  (i_hit),
        .rgn  (i_rgn),
        .base (i_base)
    );

    addr_access_check u_check (
        .ibus     (req_ibus),
        .core     (req_core),
        .wr       (req_write),
        .size     (req_size),
        .addr     (req_addr),
        .d_hit    (d_hit),
        .d_rgn    (d_rgn),
        .d_base   (d_base),
        .i_hit    (i_hit),
        .i_rgn    (i_rgn),
        .i_base   (i_base),
        .sel      (c_sel),
        .offset   (c_off),
        .dec_err  (c_err),
        .misalign (c_mis)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_sel      <= '0;
            rsp_offset   <= '0;
            rsp_dec_err  <= 1'b0;
            rsp_misalign <= 1'b0;
        end else begin
            rsp_sel      <= c_sel;
            rsp_offset   <= c_off;
            rsp_dec_err  <= c_err;
            rsp_misalign <= c_mis;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/sys_addr_decoder_chk.sv
module sys_addr_decoder_chk
    import addr_dec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_core,
    input logic               req_ibus,
    input logic               req_write,
    input logic [1:0]         req_size,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_valid,
    input logic [NUM_RGN-1:0] rsp_sel,
    input logic [ADDR_W-1:0]  rsp_offset,
    input logic               rsp_dec_err,
    input logic               rsp_misalign
);

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_req_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_sel == '0 && rsp_offset == '0 && !rsp_dec_err && !rsp_misalign));

    p_sel_onehot_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_sel));

    p_one_outcome_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({|rsp_sel, rsp_dec_err, rsp_misalign}) == 1));

    p_off_zero_r13: assert property (@(posedge clk) disable iff (rst)
        (rsp_sel == '0) |-> (rsp_offset == '0));

    p_core1_fast_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_core) |=> !rsp_sel[RG_RTCFAST]);

    p_flash_write_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_sel[RG_XFLASH]);

    p_ibus_unaligned_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ibus && req_addr[1:0] != 2'b00 && req_size != SZ_BAD)
        |=> (rsp_misalign && rsp_sel == '0));

    p_dbus_aligned_free_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ibus) |=> !rsp_misalign);

    p_bad_size_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == SZ_BAD) |=> rsp_dec_err);

endmodule

bind sys_addr_decoder sys_addr_decoder_chk i_sys_addr_decoder_chk (.*);

// File: tb/test_sys_addr_decoder.sv
module test_sys_addr_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_core, req_ibus, req_write;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic [9:0]  rsp_sel;
    logic [31:0] rsp_offset;
    logic        rsp_dec_err, rsp_misalign;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_addr_decoder i_sys_addr_decoder (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_core     (req_core),
        .req_ibus     (req_ibus),
        .req_write    (req_write),
        .req_size     (req_size),
        .req_addr     (req_addr),
        .rsp_valid    (rsp_valid),
        .rsp_sel      (rsp_sel),
        .rsp_offset   (rsp_offset),
        .rsp_dec_err  (rsp_dec_err),
        .rsp_misalign (rsp_misalign)
    );

    typedef struct packed {
        logic        ibus;
        logic        core;
        logic        wr;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [9:0]  sel;
        logic [31:0] off;
        logic        err;
        logic        mis;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,2'd2,32'h3F40_0010,10'h001,32'h0000_0010,1'b0,1'b0,8'd2},  // R2 flash
        '{1'b0,1'b0,1'b1,2'd2,32'h3F80_0004,10'h002,32'h0000_0004,1'b0,1'b0,8'd2},  // R2 ext sram write
        '{1'b0,1'b1,1'b0,2'd2,32'h3FF4_0000,10'h004,32'h0004_0000,1'b0,1'b0,8'd2},  // R2 peripherals
        '{1'b0,1'b0,1'b0,2'd2,32'h3FF8_1FFC,10'h100,32'h0000_1FFC,1'b0,1'b0,8'd3},  // R3 rtc fast
        '{1'b0,1'b0,1'b0,2'd2,32'h3FF9_8000,10'h010,32'h0000_8000,1'b0,1'b0,8'd3},  // R3 rom1
        '{1'b0,1'b1,1'b0,2'd2,32'h3FFA_E000,10'h080,32'h0000_0000,1'b0,1'b0,8'd3},  // R3 sram2 base
        '{1'b0,1'b0,1'b1,2'd2,32'h3FFF_FFFC,10'h040,32'h0001_FFFC,1'b0,1'b0,8'd3},  // R3 sram1 top
        '{1'b1,1'b0,1'b0,2'd2,32'h4000_0000,10'h008,32'h0000_0000,1'b0,1'b0,8'd4},  // R4 rom0
        '{1'b1,1'b1,1'b0,2'd2,32'h4009_FFFC,10'h020,32'h0002_FFFC,1'b0,1'b0,8'd4},  // R4 sram0
        '{1'b1,1'b0,1'b0,2'd2,32'h400A_0010,10'h040,32'h0000_0010,1'b0,1'b0,8'd4},  // R4 sram1
        '{1'b1,1'b0,1'b0,2'd2,32'h400C_1000,10'h100,32'h0000_1000,1'b0,1'b0,8'd4},  // R4 rtc fast
        '{1'b1,1'b0,1'b0,2'd2,32'h400C_2000,10'h001,32'h0000_0000,1'b0,1'b0,8'd4},  // R4 flash base
        '{1'b1,1'b1,1'b0,2'd2,32'h40BF_FFFC,10'h001,32'h00B3_DFFC,1'b0,1'b0,8'd4},  // R4 flash top
        '{1'b0,1'b1,1'b1,2'd2,32'h5000_1FFC,10'h200,32'h0000_1FFC,1'b0,1'b0,8'd5},  // R5 slow, dbus
        '{1'b1,1'b0,1'b0,2'd2,32'h5000_0000,10'h200,32'h0000_0000,1'b0,1'b0,8'd5},  // R5 slow, ibus
        '{1'b0,1'b0,1'b0,2'd2,32'h5000_2000,10'h000,32'h0000_0000,1'b1,1'b0,8'd5},  // R5 above slow
        '{1'b0,1'b0,1'b0,2'd2,32'h4000_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd6},  // R6 ibus addr on dbus
        '{1'b1,1'b0,1'b0,2'd2,32'h3FFE_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd6},  // R6 dbus addr on ibus
        '{1'b0,1'b0,1'b0,2'd2,32'h3FC0_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd7},  // R7
        '{1'b0,1'b0,1'b0,2'd2,32'h3FF8_2000,10'h000,32'h0000_0000,1'b1,1'b0,8'd7},  // R7
        '{1'b0,1'b0,1'b0,2'd2,32'h3FFA_DFFC,10'h000,32'h0000_0000,1'b1,1'b0,8'd7},  // R7
        '{1'b1,1'b0,1'b0,2'd2,32'h4006_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd7},  // R7
        '{1'b0,1'b1,1'b0,2'd2,32'h3FF8_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd8},  // R8 dbus
        '{1'b1,1'b1,1'b0,2'd2,32'h400C_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd8},  // R8 ibus
        '{1'b1,1'b0,1'b0,2'd2,32'h4000_0002,10'h000,32'h0000_0000,1'b0,1'b1,8'd9},  // R9 addr
        '{1'b1,1'b0,1'b0,2'd1,32'h4000_0000,10'h000,32'h0000_0000,1'b0,1'b1,8'd9},  // R9 size
        '{1'b0,1'b0,1'b0,2'd0,32'h3FFE_0003,10'h040,32'h0000_0003,1'b0,1'b0,8'd10}, // R10 byte
        '{1'b0,1'b0,1'b1,2'd1,32'h3FFA_E001,10'h080,32'h0000_0001,1'b0,1'b0,8'd10}, // R10 half odd
        '{1'b0,1'b0,1'b1,2'd2,32'h3F40_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd11}, // R11 dbus
        '{1'b1,1'b0,1'b1,2'd2,32'h400C_2000,10'h000,32'h0000_0000,1'b1,1'b0,8'd11}, // R11 ibus
        '{1'b0,1'b0,1'b0,2'd3,32'h3FFE_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd12}, // R12
        '{1'b0,1'b0,1'b0,2'd2,32'h0000_0000,10'h000,32'h0000_0000,1'b1,1'b0,8'd7},  // R7 low
        '{1'b0,1'b0,1'b0,2'd2,32'h3F3F_FFFC,10'h000,32'h0000_0000,1'b1,1'b0,8'd7}   // R7 edge
    };

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1'b1;
        req_ibus  = v.ibus;
        req_core  = v.core;
        req_write = v.wr;
        req_size  = v.size;
        req_addr  = v.addr;
    endtask

    task automatic expect_vec(input vec_t v);
        chk("valid",    int'(v.req), 32'(rsp_valid),    32'd1);
        chk("sel",      int'(v.req), 32'(rsp_sel),      32'(v.sel));
        chk("offset",   int'(v.req), rsp_offset,        v.off);
        chk("dec_err",  int'(v.req), 32'(rsp_dec_err),  32'(v.err));
        chk("misalign", int'(v.req), 32'(rsp_misalign), 32'(v.mis));
        // R13 one-hot select
        chk("onehot", 13, 32'($onehot0(rsp_sel)), 32'd1);
    endtask

    task automatic expect_quiet(input int req);
        chk("quiet valid", req, 32'(rsp_valid),    32'd0);
        chk("quiet sel",   req, 32'(rsp_sel),      32'd0);
        chk("quiet off",   req, rsp_offset,        32'd0);
        chk("quiet err",   req, 32'(rsp_dec_err),  32'd0);
        chk("quiet mis",   req, 32'(rsp_misalign), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_core = 1'b0; req_ibus = 1'b0; req_write = 1'b0;
        req_size = 2'd2; req_addr = 32'h0;
        repeat (3) @(negedge clk);
        expect_quiet(1); // R1 reset state
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            expect_vec(VEC[i]);
            req_valid = 1'b0;
        end

        // R1: no request, changing address has no effect
        @(negedge clk);
        req_addr = 32'h3FFE_0000;
        @(negedge clk);
        expect_quiet(1);

        // R1: back-to-back requests, each one cycle later
        drive(VEC[0]);
        @(negedge clk);
        expect_vec(VEC[0]);
        drive(VEC[7]);
        @(negedge clk);
        expect_vec(VEC[7]);
        req_valid = 1'b0;
        @(negedge clk);
        expect_quiet(1);

        // R1: reset while a response is held clears it
        drive(VEC[3]);
        @(negedge clk);
        expect_vec(VEC[3]);
        rst = 1'b1;
        @(negedge clk);
        expect_quiet(1);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        expect_quiet(1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule